// File: doc/BRIEF.md
# Audio Soft-Mute and Automute Controller

This block sits in a stereo audio sample path and decides whether the stream is muted. When it is muted, it fades the samples smoothly instead of cutting them off. A mute can be requested in three ways: an active-low external mute pin, a mute register bit, or an automute status. The automute status rises after a long run of digital silence on both channels. A separate flag tells the block that the external pin is left undriven. In that case the automute status itself acts as the pin's mute request. If the pin is instead driven high, automute is ignored unless a zero-detect override bit is set.

Each accepted left/right pair (one `in_valid` pulse) is multiplied by the current gain. The gain runs from 256/256 down to 0/256. The product is shifted right arithmetically by 8 and truncated to the sample width. It appears one clock later with `out_valid`. The gain moves one step per accepted pair, toward zero while a mute is requested and back toward full scale otherwise.

The gain is kept by a four-state machine:
- `ST_PASS`: full gain.
- `ST_FALL`: ramping down.
- `ST_SILENT`: zero gain.
- `ST_RISE`: ramping up.

Its transitions, all taken only on an accepted pair, are:
- PASS→FALL when a mute is requested.
- FALL→SILENT when the gain reaches 0.
- FALL→RISE, or FALL→PASS from gain 255, when the request drops.
- SILENT→RISE when the request drops.
- RISE→PASS when the gain reaches full.
- RISE→FALL, or RISE→SILENT from gain 1, when a mute is requested again.

Top module: `audio_mute_ctrl`

## Requirements
- R1: With no mute request and full gain, `out_left`/`out_right` equal `in_left`/`in_right` of an accepted pair, one clock after the `in_valid` cycle, with `out_valid` high in that cycle.
- R2: While `mute_pin_float` is 0 and `mute_pin_n` is 0, `mute_req` is 1 in the same cycle, combinationally.
- R3: While a mute is requested, each accepted pair is output as (sample × g) >>> 8. Here g is the gain before that pair, starting at 256. g then drops by 1, down to 0, so that from the 257th pair on the outputs are 0.
- R4: With no request, g rises by 1 per accepted pair up to 256, at the same rate as R3. A request change in the middle of a ramp reverses the ramp from the current gain.
- R5: `reg_mute`=1 sets `mute_req` to 1 whatever the pin state is.
- R6: `auto_muted` becomes 1 one clock after the 1024th consecutive accepted pair that has both channels equal to 0. A pair with only one zero channel restarts the count.
- R7: `auto_muted` returns to 0 one clock after any accepted pair that has a nonzero channel.
- R8: With `mute_pin_float`=1, `mute_req` = `auto_muted` OR `reg_mute`.
- R9: With `mute_pin_float`=0 and `mute_pin_n`=1, `auto_muted` raises `mute_req` only when `reg_zero_ovr`=1.
- R10: Cycles with `in_valid`=0 do not move the gain or the zero count. `out_valid` is 1 only in the cycle after an `in_valid` cycle.
- R11: During reset, `out_valid`, `out_left`, `out_right`, `auto_muted` are 0, and the gain is full (256).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Accepts one left/right pair this cycle |
| in_left | input | 24 | Left sample, two's complement |
| in_right | input | 24 | Right sample, two's complement |
| mute_pin_n | input | 1 | External mute pin level, low requests mute |
| mute_pin_float | input | 1 | 1 when the external pin is undriven |
| reg_mute | input | 1 | Mute register bit |
| reg_zero_ovr | input | 1 | Lets automute act while the pin is driven high |
| out_valid | output | 1 | Scaled pair present |
| out_left | output | 24 | Gain-scaled left sample |
| out_right | output | 24 | Gain-scaled right sample |
| auto_muted | output | 1 | Automute status |
| mute_req | output | 1 | Effective mute request, the driven-mute indication |

## Verification
`mute_req` is combinational, so the bench checks it 1 ns after changing the inputs, with no clock edge in between. `out_valid`, the scaled samples and `auto_muted` are each one register after an accepted pair. The bench drives each pair on a falling edge and samples 1 ns after the next rising edge. It compares against its own gain and zero-run model, which is advanced by one step per pair. Idle cycles between pairs let it confirm that `out_valid` falls and that nothing advances without `in_valid`.

// File: rtl/amute_pkg.sv
package amute_pkg;
    typedef enum logic [1:0] {
        ST_PASS,
        ST_FALL,
        ST_SILENT,
        ST_RISE
    } ramp_state_t;
endpackage

// File: rtl/zero_run_detect.sv
module zero_run_detect #(
    parameter int DATA_W  = 24,
    parameter int RUN_LEN = 1024
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              valid,
    input  logic [DATA_W-1:0] left,
    input  logic [DATA_W-1:0] right,
    output logic              run_hit
);
    localparam int CNT_W = $clog2(RUN_LEN + 1);
    localparam logic [CNT_W-1:0] RUN_MAX = CNT_W'(RUN_LEN);
    localparam logic [CNT_W-1:0] ONE     = CNT_W'(1);

    logic [CNT_W-1:0] cnt;
    logic             both_zero;

    assign both_zero = (left == '0) && (right == '0);

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt <= '0;
        end else if (valid) begin
            if (!both_zero)
                cnt <= '0;
            else if (cnt != RUN_MAX)
                cnt <= cnt + ONE;
        end
    end

    assign run_hit = (cnt == RUN_MAX);

    assert_cnt_bounded_R6: assert property (@(posedge clk) disable iff (!rst_n)
        cnt <= RUN_MAX);
    assert_set_on_last_zero_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (valid && both_zero && cnt == RUN_MAX - ONE) |=> run_hit);
    assert_clear_on_nonzero_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (valid && !both_zero) |=> !run_hit);
    assert_idle_holds_R10: assert property (@(posedge clk) disable iff (!rst_n)
        !valid |=> $stable(cnt));
endmodule

// File: rtl/mute_select.sv
module mute_select (
    input  logic clk,
    input  logic rst_n,
    input  logic pin_n,
    input  logic pin_float,
    input  logic reg_mute,
    input  logic zd_ovr,
    input  logic auto_hit,
    output logic req
);
    always_comb begin
        if (pin_float)
            req = auto_hit | reg_mute;
        else if (!pin_n)
            req = 1'b1;
        else
            req = reg_mute | (zd_ovr & auto_hit);
    end

    assert_pin_low_mutes_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (!pin_float && !pin_n) |-> req);
    assert_reg_mutes_R5: assert property (@(posedge clk) disable iff (!rst_n)
        reg_mute |-> req);
    assert_high_blocks_auto_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (!pin_float && pin_n && !reg_mute && !zd_ovr) |-> !req);
endmodule

// File: rtl/gain_ramp.sv
module gain_ramp
    import amute_pkg::*;
#(
    parameter int STEPS = 256,
    localparam int GW   = $clog2(STEPS) + 1
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          valid,
    input  logic          req,
    output logic [GW-1:0] gain
);
    localparam logic [GW-1:0] FULL = GW'(STEPS);
    localparam logic [GW-1:0] ONE  = GW'(1);

    ramp_state_t   st, st_nx;
    logic [GW-1:0] gain_nx;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st   <= ST_PASS;
            gain <= FULL;
        end else begin
            st   <= st_nx;
            gain <= gain_nx;
        end
    end

    always_comb begin
        st_nx   = st;
        gain_nx = gain;
        if (valid) begin
            unique case (st)
                ST_PASS: begin
                    if (req) begin
                        st_nx   = ST_FALL;
                        gain_nx = gain - ONE;
                    end
                end
                ST_FALL: begin
                    if (!req) begin
                        gain_nx = gain + ONE;
                        st_nx   = (gain == FULL - ONE) ? ST_PASS : ST_RISE;
                    end else begin
                        gain_nx = gain - ONE;
                        st_nx   = (gain == ONE) ? ST_SILENT : ST_FALL;
                    end
                end
                ST_SILENT: begin
                    if (!req) begin
                        st_nx   = ST_RISE;
                        gain_nx = ONE;
                    end
                end
                ST_RISE: begin
                    if (req) begin
                        gain_nx = gain - ONE;
                        st_nx   = (gain == ONE) ? ST_SILENT : ST_FALL;
                    end else begin
                        gain_nx = gain + ONE;
                        st_nx   = (gain == FULL - ONE) ? ST_PASS : ST_RISE;
                    end
                end
            endcase
        end
    end

    assert_pass_full_R1: assert property (@(posedge clk) disable iff (!rst_n)
        (st == ST_PASS) |-> (gain == FULL));
    assert_silent_zero_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (st == ST_SILENT) |-> (gain == '0));
    assert_step_down_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (valid && req && gain != '0) |=> (gain == $past(gain) - ONE));
    assert_step_up_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (valid && !req && gain != FULL) |=> (gain == $past(gain) + ONE));
    assert_idle_gain_R10: assert property (@(posedge clk) disable iff (!rst_n)
        !valid |=> $stable(gain));
endmodule

// File: rtl/sample_scaler.sv
module sample_scaler #(
    parameter int DATA_W = 24,
    parameter int GW     = 9,
    parameter int SHIFT  = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              valid,
    input  logic [DATA_W-1:0] left,
    input  logic [DATA_W-1:0] right,
    input  logic [GW-1:0]     gain,
    output logic              out_valid,
    output logic [DATA_W-1:0] out_left,
    output logic [DATA_W-1:0] out_right
);
    localparam int PW = DATA_W + GW + 1;
    localparam logic [GW-1:0] FULL = GW'(1 << SHIFT);

    logic signed [PW-1:0] gain_s;
    assign gain_s = $signed({{(DATA_W){1'b0}}, 1'b0, gain});

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            out_valid <= 1'b0;
            out_left  <= '0;
            out_right <= '0;
        end else begin
            out_valid <= valid;
            if (valid) begin
                out_left  <= DATA_W'(($signed({{(GW+1){left[DATA_W-1]}}, left}) * gain_s) >>> SHIFT);
                out_right <= DATA_W'(($signed({{(GW+1){right[DATA_W-1]}}, right}) * gain_s) >>> SHIFT);
            end
        end
    end

    assert_valid_follows_R10: assert property (@(posedge clk) disable iff (!rst_n)
        valid |=> out_valid);
    assert_no_spurious_R10: assert property (@(posedge clk) disable iff (!rst_n)
        !valid |=> !out_valid);
    assert_full_passthrough_R1: assert property (@(posedge clk) disable iff (!rst_n)
        (valid && gain == FULL) |=> (out_left == $past(left) && out_right == $past(right)));
    assert_zero_gain_silent_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (valid && gain == '0) |=> (out_left == '0 && out_right == '0));
endmodule

// File: rtl/audio_mute_ctrl.sv
module audio_mute_ctrl #(
    parameter int DATA_W     = 24,
    parameter int ZERO_RUN   = 1024,
    parameter int GAIN_STEPS = 256
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              in_valid,
    input  logic [DATA_W-1:0] in_left,
    input  logic [DATA_W-1:0] in_right,
    input  logic              mute_pin_n,
    input  logic              mute_pin_float,
    input  logic              reg_mute,
    input  logic              reg_zero_ovr,
    output logic              out_valid,
    output logic [DATA_W-1:0] out_left,
    output logic [DATA_W-1:0] out_right,
    output logic              auto_muted,
    output logic              mute_req
);
    localparam int SHIFT = $clog2(GAIN_STEPS);
    localparam int GW    = SHIFT + 1;

    logic [GW-1:0] gain;

    zero_run_detect #(.DATA_W(DATA_W), .RUN_LEN(ZERO_RUN)) u_zero (
        .clk(clk), .rst_n(rst_n), .valid(in_valid),
        .left(in_left), .right(in_right), .run_hit(auto_muted)
    );

    mute_select u_sel (
        .clk(clk), .rst_n(rst_n), .pin_n(mute_pin_n), .pin_float(mute_pin_float),
        .reg_mute(reg_mute), .zd_ovr(reg_zero_ovr), .auto_hit(auto_muted), .req(mute_req)
    );

    gain_ramp #(.STEPS(GAIN_STEPS)) u_ramp (
        .clk(clk), .rst_n(rst_n), .valid(in_valid), .req(mute_req), .gain(gain)
    );

    sample_scaler #(.DATA_W(DATA_W), .GW(GW), .SHIFT(SHIFT)) u_scale (
        .clk(clk), .rst_n(rst_n), .valid(in_valid), .left(in_left), .right(in_right),
        .gain(gain), .out_valid(out_valid), .out_left(out_left), .out_right(out_right)
    );
endmodule

// File: tb/test_audio_mute_ctrl.sv
module test_audio_mute_ctrl;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        in_valid = 1'b0;
    logic [23:0] in_left = '0, in_right = '0;
    logic        mute_pin_n = 1'b1, mute_pin_float = 1'b0, reg_mute = 1'b0, reg_zero_ovr = 1'b0;
    logic        out_valid, auto_muted, mute_req;
    logic [23:0] out_left, out_right;

    int checks = 0;
    int failures = 0;
    int bg = 256;
    int bz = 0;
    bit done = 0;

    always #5 clk = ~clk;

    audio_mute_ctrl i_audio_mute_ctrl (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_left(in_left), .in_right(in_right),
        .mute_pin_n(mute_pin_n), .mute_pin_float(mute_pin_float), .reg_mute(reg_mute),
        .reg_zero_ovr(reg_zero_ovr), .out_valid(out_valid), .out_left(out_left),
        .out_right(out_right), .auto_muted(auto_muted), .mute_req(mute_req)
    );

    task automatic check(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    function automatic bit model_req();
        bit am = (bz == 1024);
        if (mute_pin_float) return am || reg_mute;
        if (!mute_pin_n) return 1'b1;
        return reg_mute || (reg_zero_ovr && am);
    endfunction

    function automatic logic [23:0] scale(input logic [23:0] s, input int g);
        longint p = longint'($signed(s)) * longint'(g);
        return 24'(p >>> 8);
    endfunction

    function automatic logic [23:0] pat(input int i, input int k);
        return 24'(i * 40503 + k * 7919 - 3000000);
    endfunction

    task automatic send(input logic [23:0] l, input logic [23:0] r, input string tag);
        bit rq = model_req();
        logic [23:0] el = scale(l, bg);
        logic [23:0] er = scale(r, bg);
        @(negedge clk);
        in_valid = 1'b1; in_left = l; in_right = r;
        @(posedge clk); #1;
        in_valid = 1'b0;
        check(out_valid == 1'b1, {tag, " out_valid"}, 32'(out_valid), 1);
        check(out_left == el, {tag, " left"}, 32'(out_left), 32'(el));
        check(out_right == er, {tag, " right"}, 32'(out_right), 32'(er));
        if (rq && bg > 0) bg--;
        else if (!rq && bg < 256) bg++;
        if (l == 0 && r == 0) begin if (bz < 1024) bz++; end
        else bz = 0;
    endtask

    task automatic t_reset();
        repeat (3) @(posedge clk);
        #1;
        check(out_valid == 0, "R11 out_valid", 32'(out_valid), 0);
        check(out_left == 0 && out_right == 0, "R11 samples", 32'(out_left), 0);
        check(auto_muted == 0, "R11 auto_muted", 32'(auto_muted), 0);
        @(negedge clk); rst_n = 1'b1;
    endtask

    task automatic t_pass();
        send(24'h7FFFFF, 24'h800000, "R1 extremes");
        send(24'h000001, 24'hFFFFFF, "R1 small");
        for (int i = 0; i < 8; i++) send(pat(i, 1), pat(i, 2), "R1 pattern");
        check(out_left == pat(7, 1), "R1 exact copy", 32'(out_left), 32'(pat(7, 1)));
    endtask

    task automatic t_pin_ramp();
        mute_pin_n = 1'b0; #1;
        check(mute_req == 1, "R2 pin low", 32'(mute_req), 1);
        for (int i = 0; i < 256; i++) send(pat(i, 3), pat(i, 5), "R3 ramp down");
        send(24'h7FFFFF, 24'h800000, "R3 silent");
        check(out_left == 0 && out_right == 0, "R3 zero after ramp", 32'(out_left), 0);
        mute_pin_n = 1'b1; #1;
        check(mute_req == 0, "R2 pin released", 32'(mute_req), 0);
        for (int i = 0; i < 256; i++) send(pat(i, 7), pat(i, 11), "R4 ramp up");
        send(24'h123456, 24'hABCDEF, "R4 full again");
        check(out_left == 24'h123456, "R4 back to full", 32'(out_left), 32'h123456);
    endtask

    task automatic t_reg_reversal();
        mute_pin_float = 1'b1; mute_pin_n = 1'b1;
        reg_mute = 1'b1; #1;
        check(mute_req == 1, "R5 reg mute float", 32'(mute_req), 1);
        mute_pin_float = 1'b0; #1;
        check(mute_req == 1, "R5 reg mute pin high", 32'(mute_req), 1);
        for (int i = 0; i < 100; i++) send(pat(i, 13), pat(i, 17), "R5 ramp down");
        reg_mute = 1'b0;
        for (int i = 0; i < 110; i++) send(pat(i, 19), pat(i, 23), "R4 reversal");
        check(bg == 256, "R4 model full", 32'(bg), 256);
    endtask

    task automatic t_idle();
        reg_mute = 1'b1;
        repeat (20) @(posedge clk);
        #1;
        check(out_valid == 0, "R10 idle no out_valid", 32'(out_valid), 0);
        send(24'h400000, 24'hC00000, "R10 gain held full");
        @(posedge clk); #1;
        check(out_valid == 0, "R10 single out_valid", 32'(out_valid), 0);
        reg_mute = 1'b0;
        send(24'h000100, 24'h000200, "R10 restore");
    endtask

    task automatic t_one_channel();
        for (int i = 0; i < 1100; i++) send(24'h0, 24'h000005, "R6 one channel");
        check(auto_muted == 0, "R6 one channel no automute", 32'(auto_muted), 0);
    endtask

    task automatic t_float_auto();
        send(24'h000010, 24'h0, "R7 prime");
        mute_pin_float = 1'b1;
        for (int i = 0; i < 1023; i++) send(24'h0, 24'h0, "R6 zero run");
        check(auto_muted == 0, "R6 not yet at 1023", 32'(auto_muted), 0);
        check(mute_req == 0, "R8 no request yet", 32'(mute_req), 0);
        send(24'h0, 24'h0, "R6 1024th zero");
        check(auto_muted == 1, "R6 set at 1024", 32'(auto_muted), 1);
        check(mute_req == 1, "R8 float follows automute", 32'(mute_req), 1);
        for (int i = 0; i < 300; i++) send(24'h0, 24'h0, "R8 ramp on silence");
        send(24'h7FFFFF, 24'h0, "R7 nonzero at zero gain");
        check(out_left == 0, "R3 held at zero gain", 32'(out_left), 0);
        check(auto_muted == 0, "R7 cleared", 32'(auto_muted), 0);
        check(mute_req == 0, "R8 request dropped", 32'(mute_req), 0);
        for (int i = 0; i < 256; i++) send(pat(i, 29), pat(i, 31), "R4 ramp after automute");
        mute_pin_float = 1'b0;
    endtask

    task automatic t_driven_high();
        for (int i = 0; i < 1024; i++) send(24'h0, 24'h0, "R9 zero run");
        check(auto_muted == 1, "R9 automute set", 32'(auto_muted), 1);
        check(mute_req == 0, "R9 pin high blocks", 32'(mute_req), 0);
        for (int i = 0; i < 10; i++) send(24'h0, 24'h0, "R9 silence");
        send(24'h2468AC, 24'hFEDCBA, "R9 full gain kept");
        check(out_left == 24'h2468AC, "R9 no ramp", 32'(out_left), 32'h2468AC);
        for (int i = 0; i < 1024; i++) send(24'h0, 24'h0, "R9 zero run 2");
        reg_zero_ovr = 1'b1; #1;
        check(mute_req == 1, "R9 override enables", 32'(mute_req), 1);
        for (int i = 0; i < 5; i++) send(24'h0, 24'h0, "R9 override ramp");
        send(24'h100000, 24'hF00000, "R9 ramped gain");
        check(out_left == scale(24'h100000, 251), "R9 gain 251", 32'(out_left), 32'(scale(24'h100000, 251)));
        reg_zero_ovr = 1'b0;
        for (int i = 0; i < 10; i++) send(pat(i, 37), pat(i, 41), "R4 settle");
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            failures++;
            $display("FAIL watchdog actual=timeout expected=finish");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        t_reset();
        t_pass();
        t_pin_ramp();
        t_reg_reversal();
        t_idle();
        t_one_channel();
        t_float_auto();
        t_driven_high();
        done = 1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule